// File: doc/BRIEF.md
# Chained Serial Switch-Enable Register

The block is the digital side of a bank of serially programmed on/off switches. A host shifts a control word in over three wires: a serial clock, a data line, and an active-low frame select. Each bit of the word, once latched, drives one switch-enable output. The serial pins are asynchronous to the block. They are oversampled by a fast system clock, and all edge detection is done on the resynchronised samples.

Several blocks can be placed in a chain. A serial output presents the bit that leaves the top of the shift register, so a word shifted into the first block shows up at the next block eight bits later. The switch-enable outputs are held in a separate latch. That latch loads only when a frame closes, so the switches never show partial words. Frames of any length are accepted. The register always keeps the most recent eight bits.

Top module: `serial_switch_reg`

## Requirements
- R1: After the active-low reset, every switch-enable output is 0 and `chain_pull_o` is 1, because the chain bit resets to 0.
- R2: Each falling serial-clock edge seen while frame select is low shifts the data bit into bit 0 and moves the older bits up. The first bit sent therefore ends in bit 7.
- R3: `sw_en_o` changes only on a rising edge of frame select, and then copies the shift register. Bit i drives `sw_en_o[i]`, where 1 means switch closed and 0 means switch open.
- R4: While frame select is high, toggling the serial clock or the data line leaves the shift register unchanged.
- R5: A frame with more than eight clocks keeps its last eight bits. A frame with fewer than eight clocks shifts the older contents up by the number of bits received.
- R6: A frame with no clocks reloads `sw_en_o` with the unchanged register contents.
- R7: On each rising serial-clock edge inside a frame, the chain bit takes register bit 7. `chain_pull_o` is 1 (pull low) when the chain bit is 0, and 0 (release) when it is 1. A word therefore reappears on the chain output during the following frame, MSB first.
- R8: Asserting reset in the middle of a frame clears both the shift register and the switch latch at once.
- R9: Each pin is seen three system clocks after it changes. If the last falling clock edge and the rise of frame select reach that point in the same cycle, that bit is not shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock pin |
| sdata_i | input | 1 | Serial data pin |
| fsel_ni | input | 1 | Active-low frame select pin |
| sw_en_o | output | WIDTH | Switch enables, 1 = closed |
| chain_pull_o | output | 1 | Open-drain chain output: 1 pulls low, 0 releases |

## Verification
Two events can land in the same cycle: the shift caused by a falling serial clock and the latch load caused by frame select rising. The bench provokes this by dropping the serial clock and raising frame select at the same instant on the last bit of a frame. It then expects the latch to hold only the first seven bits, shifted onto the old register. A behavioural pin-history model, compared on every clock, judges both this collision and the normal case.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int PIN_W   = 3;
  localparam int PIN_SCK = 2;
  localparam int PIN_DAT = 1;
  localparam int PIN_FSN = 0;
  // idle pin levels: clock low, data low, frame select high
  localparam logic [PIN_W-1:0] PIN_IDLE = 3'b001;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int              STAGES  = 2,
  parameter int              W       = 3,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     st_q[g] <= RST_VAL;
      else if (g == 0) st_q[g] <= d_i;
      else             st_q[g] <= st_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ssr_edge.sv
module ssr_edge #(
  parameter int           W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] s_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= s_i;
  end

  assign rise_o = s_i & ~prev_q;
  assign fall_o = prev_q & ~s_i;
endmodule

// File: rtl/ssr_shift.sv
module ssr_shift #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  input  logic             emit_i,
  output logic [WIDTH-1:0] word_o,
  output logic             chain_o
);
  logic [WIDTH-1:0] word_q;
  logic             chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (shift_i) word_q <= {word_q[WIDTH-2:0], bit_i};
  end

  // chain bit launches on the opposite serial edge to capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     chain_q <= 1'b0;
    else if (emit_i) chain_q <= word_q[WIDTH-1];
  end

  assign word_o  = word_q;
  assign chain_o = chain_q;
endmodule

// File: rtl/serial_switch_reg.sv
module serial_switch_reg #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             fsel_ni,
  output logic [WIDTH-1:0] sw_en_o,
  output logic             chain_pull_o
);
  import ssr_pkg::*;

  logic [PIN_W-1:0] pins_s, pins_rise, pins_fall;
  logic             data_s, fsel_s, sclk_rise, sclk_fall, fsel_rise;
  logic             chain_bit;
  logic [WIDTH-1:0] shift_q, latch_q;

  ssr_sync #(.STAGES(SYNC_STAGES), .W(PIN_W), .RST_VAL(PIN_IDLE)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({sclk_i, sdata_i, fsel_ni}),
    .q_o (pins_s)
  );

  ssr_edge #(.W(PIN_W), .RST_VAL(PIN_IDLE)) u_edge (
    .clk_i, .rst_ni,
    .s_i    (pins_s),
    .rise_o (pins_rise),
    .fall_o (pins_fall)
  );

  assign data_s    = pins_s[PIN_DAT];
  assign fsel_s    = pins_s[PIN_FSN];
  assign sclk_rise = pins_rise[PIN_SCK];
  assign sclk_fall = pins_fall[PIN_SCK];
  assign fsel_rise = pins_rise[PIN_FSN];

  ssr_shift #(.WIDTH(WIDTH)) u_shift (
    .clk_i, .rst_ni,
    .shift_i (sclk_fall & ~fsel_s),
    .bit_i   (data_s),
    .emit_i  (sclk_rise & ~fsel_s),
    .word_o  (shift_q),
    .chain_o (chain_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        latch_q <= '0;
    else if (fsel_rise) latch_q <= shift_q;
  end

  assign sw_en_o      = latch_q;
  assign chain_pull_o = ~chain_bit;
endmodule

// File: rtl/ssr_chk.sv
module ssr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] sw_en_o,
  input logic             chain_pull_o,
  input logic             sclk_rise,
  input logic             sclk_fall,
  input logic             fsel_s,
  input logic             fsel_rise,
  input logic             data_s
);
  // R2 R4
  shift_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(shift_q) |-> $past(sclk_fall && !fsel_s));
  // R2
  shift_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sclk_fall && !fsel_s) |-> shift_q == {$past(shift_q[WIDTH-2:0]), $past(data_s)});
  // R3
  latch_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sw_en_o) |-> $past(fsel_rise));
  // R3
  latch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fsel_rise) |-> sw_en_o == $past(shift_q));
  // R7
  chain_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chain_pull_o) |-> $past(sclk_rise && !fsel_s));
endmodule

bind serial_switch_reg ssr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i, .rst_ni, .shift_q, .sw_en_o, .chain_pull_o,
  .sclk_rise, .sclk_fall, .fsel_s, .fsel_rise, .data_s
);

// File: tb/tb_serial_switch_reg.sv
module tb_serial_switch_reg;
  localparam int W = 8;
  localparam int H = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sclk_i = 1'b0, sdata_i = 1'b0, fsel_ni = 1'b1;
  logic [W-1:0] sw_en_o;
  logic chain_pull_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  serial_switch_reg #(.WIDTH(W)) dut (
    .clk_i, .rst_ni, .sclk_i, .sdata_i, .fsel_ni, .sw_en_o, .chain_pull_o
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, a, e, $time);
    end
  endtask

  // reference: pin history, pins reach the logic three clocks late (R9)
  logic [2:0] hq[$];
  logic [W-1:0] m_sreg, m_sw;
  logic m_chain;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hq = {3'b001, 3'b001, 3'b001, 3'b001};
      m_sreg = '0; m_sw = '0; m_chain = 1'b0;
    end else begin
      bit fall, rise, low, frise;
      hq.push_front({sclk_i, sdata_i, fsel_ni});
      void'(hq.pop_back());
      fall  = hq[3][2] && !hq[2][2];
      rise  = !hq[3][2] && hq[2][2];
      low   = !hq[2][0];
      frise = !hq[3][0] && hq[2][0];
      if (rise && low) m_chain = m_sreg[W-1];
      if (frise)       m_sw = m_sreg;
      if (fall && low) m_sreg = {m_sreg[W-2:0], hq[2][1]};
    end
  end

  always @(negedge clk_i) if (rst_ni && !done) begin
    chk(sw_en_o === m_sw, "R3", sw_en_o, m_sw);
    chk(chain_pull_o === !m_chain, "R7", chain_pull_o, !m_chain);
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  logic [31:0] got;
  task automatic send(input logic [31:0] v, input int n, input bit collide);
    fsel_ni = 1'b0; wait_cyc(H);
    for (int i = n - 1; i >= 0; i--) begin
      sclk_i = 1'b1; sdata_i = v[i]; wait_cyc(H);
      got = {got[30:0], ~chain_pull_o};
      sclk_i = 1'b0;
      if (collide && i == 0) fsel_ni = 1'b1;
      wait_cyc(H);
    end
    fsel_ni = 1'b1; wait_cyc(2 * H);
  endtask

  initial begin
    wait_cyc(3);
    chk(sw_en_o == '0, "R1", sw_en_o, 0);
    chk(chain_pull_o == 1'b1, "R1", chain_pull_o, 1);
    rst_ni = 1'b1; wait_cyc(3);
    chk(sw_en_o == '0, "R1", sw_en_o, 0);

    send(32'hA5, 8, 0);
    chk(sw_en_o == 8'hA5, "R2", sw_en_o, 8'hA5);
    send(32'h3C, 8, 0);
    chk(sw_en_o == 8'h3C, "R3", sw_en_o, 8'h3C);

    for (int k = 0; k < 10; k++) begin
      sclk_i = ~sclk_i; sdata_i = k[0]; wait_cyc(H);
    end
    sclk_i = 1'b0; wait_cyc(H);
    chk(sw_en_o == 8'h3C, "R4", sw_en_o, 8'h3C);
    send(32'h0, 0, 0);
    chk(sw_en_o == 8'h3C, "R4", sw_en_o, 8'h3C);

    send(32'hABC, 12, 0);
    chk(sw_en_o == 8'hBC, "R5", sw_en_o, 8'hBC);
    send(32'h5, 3, 0);
    chk(sw_en_o == 8'hE5, "R5", sw_en_o, 8'hE5);
    send(32'h0, 0, 0);
    chk(sw_en_o == 8'hE5, "R6", sw_en_o, 8'hE5);

    send(32'h96, 8, 0);
    got = '0;
    send(32'h00, 8, 0);
    chk(got[7:0] == 8'h96, "R7", got[7:0], 8'h96);
    chk(sw_en_o == 8'h00, "R2", sw_en_o, 0);

    send(32'h81, 8, 1);
    chk(sw_en_o == 8'h40, "R9", sw_en_o, 8'h40);

    send(32'hFF, 8, 0);
    chk(sw_en_o == 8'hFF, "R2", sw_en_o, 8'hFF);
    fsel_ni = 1'b0; wait_cyc(H);
    for (int i = 0; i < 3; i++) begin
      sclk_i = 1'b1; sdata_i = 1'b1; wait_cyc(H);
      sclk_i = 1'b0; wait_cyc(H);
    end
    rst_ni = 1'b0; wait_cyc(2);
    chk(sw_en_o == '0, "R8", sw_en_o, 0);
    chk(chain_pull_o == 1'b1, "R8", chain_pull_o, 1);
    rst_ni = 1'b1; wait_cyc(H);
    fsel_ni = 1'b1; wait_cyc(2 * H);
    chk(sw_en_o == '0, "R8", sw_en_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule